// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Buffer

This block receives asynchronous serial characters on one input line and turns each into a parallel byte. A two-entry first-in first-out buffer holds the bytes until a read strobe takes them. A tick input at sixteen times the bit rate paces all of the bit timing. The block checks that each start bit is real, takes every later bit at its middle sample, and assembles the character with its first bit as bit 0. At run time the mode inputs choose 7- or 8-bit characters, parity off or on with odd or even sense, and one or two stop bits.

A parity flag and a framing flag are stored with each byte and shown for the byte at the head of the buffer. A character that completes while both entries are full is discarded, and a one-cycle overrun pulse reports the loss. Two interrupt outputs each have their own enable. The buffer-level interrupt is raised while the fill count reaches a chosen level of one or two bytes. The error interrupt pulses once for each completed character that has a parity or framing error. When the channel enable is low, the receiver stays idle and ignores the line.

Top module: `uart_rx_buf`

## Requirements
- R1: Data bits are stored least significant first: the first bit after the start bit goes to `rx_data[0]`, and a high line level is stored as 1.
- R2: With `char8` high, a character has 8 data bits. With `char8` low, it has 7 data bits and `rx_data[7]` reads 0.
- R3: With `par_on` high, one parity bit follows the data. `par_odd` high asks for an odd count of ones over the data and parity bits, and low asks for an even count. A mismatch sets `head_par_err` for that byte.
- R4: With `par_on` low, no parity bit is taken, the bit after the data is treated as a stop bit, `par_odd` has no effect and `head_par_err` stays 0.
- R5: `stop2` high expects two stop bits and low expects one. If any expected stop bit is sampled low, `head_frm_err` is set for that byte.
- R6: A falling edge starts a character only if the line is still low at the middle of the start bit (8 ticks later). A shorter low pulse stores nothing.
- R7: The buffer holds up to two bytes and returns them oldest first. `fill_cnt` reports 0 to 2. `rd_pop` removes the head byte, and a pop while the buffer is empty is ignored. A store and a pop in the same cycle with one byte held leave `fill_cnt` at 1, with the new byte at the head.
- R8: A character that completes while `fill_cnt` is 2 is discarded. `ovr_err` pulses for one cycle, and the stored bytes are unchanged.
- R9: `full_irq` is high when `full_irq_en` is high and `fill_cnt` is at least the level: 2 when `full_lvl2` is high, 1 when it is low. Otherwise it is 0.
- R10: `err_irq` pulses for one cycle after a character completes with a parity or framing error, but only when `err_irq_en` is high.
- R11: After reset, or while `rx_en` is low, the receiver is idle: the line is ignored, `fill_cnt` is 0 after reset, and both interrupts are low.
- R12: Bit timing advances only on cycles with `tick16` high, so one bit lasts 16 ticks at any tick rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample tick at sixteen times the bit rate |
| rx_en | input | 1 | Channel enable |
| rxd | input | 1 | Serial line, idle high |
| char8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_on | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop2 | input | 1 | 1: two stop bits, 0: one stop bit |
| full_lvl2 | input | 1 | Buffer interrupt level, 1: two bytes, 0: one byte |
| full_irq_en | input | 1 | Enable for the buffer-level interrupt |
| err_irq_en | input | 1 | Enable for the receive-error interrupt |
| rd_pop | input | 1 | Removes the head byte |
| rx_data | output | 8 | Head byte |
| head_par_err | output | 1 | Parity error flag of the head byte |
| head_frm_err | output | 1 | Framing error flag of the head byte |
| fill_cnt | output | 2 | Number of bytes held |
| ovr_err | output | 1 | One-cycle pulse when a byte is discarded |
| full_irq | output | 1 | Buffer-level interrupt |
| err_irq | output | 1 | Receive-error interrupt pulse |

## Verification
A completed character being stored and a read strobe popping the buffer can fall in the same clock cycle. The bench provokes this by holding one byte and sending a second. It raises `rd_pop` for the single cycle in which the new byte is stored, a cycle it computes from the synchronizer depth, the half-bit start check and the frame length. A correct result leaves `fill_cnt` at 1, puts the new byte at the head and gives no overrun pulse. Losing either the store or the pop would show as a count of 0 or 2, or as the old byte still at the head.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  typedef struct packed {
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_word_t;

  localparam int WORD_W = DATA_W + 2;
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b1;
        else     q <= din;
      end
      assign dout = q;
    end else begin : g_chain
      logic [STAGES-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '1;
        else     q <= {q[STAGES-2:0], din};
      end
      assign dout = q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     en,
  input  logic     line,
  input  logic     char8,
  input  logic     par_on,
  input  logic     par_odd,
  input  logic     stop2,
  output logic     done,
  output rx_word_t word
);
  localparam int SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] HALF = SUB_W'(OSR / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OSR - 1);

  rx_state_t         state;
  logic [SUB_W-1:0]  sub;
  logic [2:0]        bitn;
  logic              stopn;
  logic [DATA_W-1:0] sh;
  logic              pacc;
  logic              ferr;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state <= ST_IDLE;
      sub   <= '0;
      bitn  <= '0;
      stopn <= 1'b0;
      sh    <= '0;
      pacc  <= 1'b0;
      ferr  <= 1'b0;
      done  <= 1'b0;
      word  <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            if (!line) begin
              state <= ST_START;
              sub   <= '0;
            end
          end
          ST_START: begin
            if (sub == HALF) begin
              sub <= '0;
              if (!line) begin
                state <= ST_DATA;
                bitn  <= '0;
                pacc  <= 1'b0;
                ferr  <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          ST_DATA: begin
            if (sub == LAST) begin
              sub  <= '0;
              sh   <= {line, sh[DATA_W-1:1]};
              pacc <= pacc ^ line;
              if (bitn == (char8 ? 3'd7 : 3'd6)) begin
                state <= par_on ? ST_PAR : ST_STOP;
                stopn <= 1'b0;
              end else begin
                bitn <= bitn + 1'b1;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          ST_PAR: begin
            if (sub == LAST) begin
              sub   <= '0;
              pacc  <= pacc ^ line;
              state <= ST_STOP;
            end else begin
              sub <= sub + 1'b1;
            end
          end
          ST_STOP: begin
            if (sub == LAST) begin
              sub <= '0;
              if (stop2 && !stopn) begin
                stopn <= 1'b1;
                ferr  <= ferr | !line;
              end else begin
                done      <= 1'b1;
                word.frm  <= ferr | !line;
                word.par  <= par_on & (pacc ^ par_odd);
                word.data <= char8 ? sh : {1'b0, sh[DATA_W-1:1]};
                state     <= ST_IDLE;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !en |=> state == ST_IDLE);

  assert_bit7_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !char8) |-> !word.data[7]);

  assert_start_reject_R6: assert property (@(posedge clk) disable iff (rst)
    (en && tick && state == ST_START && sub == HALF && line) |=> state == ST_IDLE);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr,
  input  logic [W-1:0]               wdata,
  input  logic                       rd,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] cnt,
  output logic                       overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          accept, take;

  assign accept = wr && (cnt != FULL);
  assign take   = rd && (cnt != '0);

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= wr && (cnt == FULL);
      if (accept) wr_ptr <= step(wr_ptr);
      if (take)   rd_ptr <= step(rd_ptr);
      cnt <= cnt + CW'(accept) - CW'(take);
    end
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL);

  assert_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && rd && !wr) |=> cnt == '0);

  assert_drop_when_full_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && cnt == FULL && !rd) |=> (cnt == FULL && overrun));
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick16,
  input  logic          rx_en,
  input  logic          rxd,
  input  logic          char8,
  input  logic          par_on,
  input  logic          par_odd,
  input  logic          stop2,
  input  logic          full_lvl2,
  input  logic          full_irq_en,
  input  logic          err_irq_en,
  input  logic          rd_pop,
  output logic [7:0]    rx_data,
  output logic          head_par_err,
  output logic          head_frm_err,
  output logic [CW-1:0] fill_cnt,
  output logic          ovr_err,
  output logic          full_irq,
  output logic          err_irq
);
  logic     line_s;
  logic     done;
  rx_word_t word;
  rx_word_t head;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line_s)
  );

  uart_rx_frame #(.OSR(OSR)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick16),
    .en     (rx_en),
    .line   (line_s),
    .char8  (char8),
    .par_on (par_on),
    .par_odd(par_odd),
    .stop2  (stop2),
    .done   (done),
    .word   (word)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk    (clk),
    .rst    (rst),
    .wr     (done),
    .wdata  (word),
    .rd     (rd_pop),
    .rdata  (head),
    .cnt    (fill_cnt),
    .overrun(ovr_err)
  );

  assign rx_data      = head.data;
  assign head_par_err = head.par;
  assign head_frm_err = head.frm;
  assign full_irq     = full_irq_en && (fill_cnt >= (full_lvl2 ? CW'(2) : CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) err_irq <= 1'b0;
    else     err_irq <= err_irq_en && done && (word.par || word.frm);
  end

  assert_err_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !err_irq_en |=> !err_irq);

  assert_full_irq_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == '0) |-> !full_irq);
endmodule

// File: tb/uart_rx_buf_bench.sv
`timescale 1ns/1ps
module uart_rx_buf_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick16 = 1'b1;
  logic rx_en = 1'b0, rxd = 1'b1;
  logic char8 = 1'b1, par_on = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
  logic full_lvl2 = 1'b0, full_irq_en = 1'b0, err_irq_en = 1'b0, rd_pop = 1'b0;
  logic [7:0] rx_data;
  logic head_par_err, head_frm_err, ovr_err, full_irq, err_irq;
  logic [1:0] fill_cnt;

  int tests = 0, fails = 0, tdiv = 1, tph = 0, ovr_seen = 0, irq_seen = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_buf u_uart_rx_buf (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_en(rx_en), .rxd(rxd),
    .char8(char8), .par_on(par_on), .par_odd(par_odd), .stop2(stop2),
    .full_lvl2(full_lvl2), .full_irq_en(full_irq_en), .err_irq_en(err_irq_en),
    .rd_pop(rd_pop), .rx_data(rx_data), .head_par_err(head_par_err),
    .head_frm_err(head_frm_err), .fill_cnt(fill_cnt), .ovr_err(ovr_err),
    .full_irq(full_irq), .err_irq(err_irq)
  );

  always @(negedge clk) begin
    tph    <= (tph + 1 >= tdiv) ? 0 : tph + 1;
    tick16 <= (tph == 0);
    if (ovr_err) ovr_seen <= ovr_seen + 1;
    if (err_irq) irq_seen <= irq_seen + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mode(input logic l8, input logic pe, input logic po, input logic s2);
    char8 = l8; par_on = pe; par_odd = po; stop2 = s2;
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit use_par,
                      input logic pbit, input int nstop, input logic stop_v);
    int bp = 16 * tdiv;
    rxd = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      repeat (bp) @(negedge clk);
    end
    if (use_par) begin
      rxd = pbit;
      repeat (bp) @(negedge clk);
    end
    for (int i = 0; i < nstop; i++) begin
      rxd = (i == nstop - 1) ? stop_v : 1'b1;
      repeat (bp) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * bp) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset fill", fill_cnt, 0);
    check("R11 reset full_irq", full_irq, 0);
    check("R11 reset err_irq", err_irq, 0);
  endtask

  task automatic t_basic();
    mode(1, 0, 0, 0);
    send(8'hA5, 8, 0, 0, 1, 1);
    check("R1 data", rx_data, 8'hA5);
    check("R7 fill one", fill_cnt, 1);
    check("R5 no frm", head_frm_err, 0);
    pop();
    check("R7 fill after pop", fill_cnt, 0);
    pop();
    check("R7 empty pop ignored", fill_cnt, 0);
  endtask

  task automatic t_seven();
    mode(0, 0, 0, 0);
    send(8'hFF, 7, 0, 0, 1, 1);
    check("R2 seven-bit data", rx_data, 8'h7F);
    pop();
    mode(1, 0, 0, 0);
  endtask

  task automatic t_parity();
    mode(1, 1, 0, 0);
    send(8'h35, 8, 1, ^8'h35, 1, 1);
    check("R3 even ok", head_par_err, 0);
    check("R3 even data", rx_data, 8'h35);
    pop();
    send(8'h35, 8, 1, ~^8'h35, 1, 1);
    check("R3 even bad", head_par_err, 1);
    pop();
    mode(1, 1, 1, 0);
    send(8'h35, 8, 1, ~^8'h35, 1, 1);
    check("R3 odd ok", head_par_err, 0);
    pop();
    send(8'h35, 8, 1, ^8'h35, 1, 1);
    check("R3 odd bad", head_par_err, 1);
    pop();
  endtask

  task automatic t_nopar();
    mode(1, 0, 1, 0);
    send(8'h0F, 8, 0, 0, 1, 1);
    check("R4 no parity data", rx_data, 8'h0F);
    check("R4 no parity flag", head_par_err, 0);
    check("R4 no frm", head_frm_err, 0);
    pop();
  endtask

  task automatic t_stop();
    mode(1, 0, 0, 1);
    send(8'h5A, 8, 0, 0, 2, 1);
    check("R5 two stops ok", head_frm_err, 0);
    pop();
    send(8'h5A, 8, 0, 0, 2, 0);
    check("R5 second stop low", head_frm_err, 1);
    check("R5 one byte stored", fill_cnt, 1);
    pop();
    mode(1, 0, 0, 0);
    send(8'h3C, 8, 0, 0, 1, 0);
    check("R5 single stop low", head_frm_err, 1);
    pop();
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    check("R6 glitch rejected", fill_cnt, 0);
  endtask

  task automatic t_fifo_irq();
    full_irq_en = 1; full_lvl2 = 1;
    send(8'h11, 8, 0, 0, 1, 1);
    check("R9 level2 one byte", full_irq, 0);
    full_lvl2 = 0;
    #1 check("R9 level1 one byte", full_irq, 1);
    full_lvl2 = 1;
    send(8'h22, 8, 0, 0, 1, 1);
    check("R7 fill two", fill_cnt, 2);
    check("R9 level2 two bytes", full_irq, 1);
    full_irq_en = 0;
    #1 check("R9 disabled", full_irq, 0);
    send(8'h33, 8, 0, 0, 1, 1);
    check("R8 overrun pulse", ovr_seen, 1);
    check("R8 fill held", fill_cnt, 2);
    check("R7 oldest first", rx_data, 8'h11);
    pop();
    check("R8 second kept", rx_data, 8'h22);
    pop();
    check("R7 drained", fill_cnt, 0);
  endtask

  task automatic t_err_irq();
    mode(1, 1, 0, 0);
    err_irq_en = 0;
    send(8'h01, 8, 1, 0, 1, 1);
    check("R10 gated off", irq_seen, 0);
    pop();
    err_irq_en = 1;
    send(8'h01, 8, 1, 0, 1, 1);
    check("R10 parity irq", irq_seen, 1);
    pop();
    send(8'h01, 8, 1, 1, 1, 1);
    check("R10 clean frame no irq", irq_seen, 1);
    pop();
    err_irq_en = 0;
    mode(1, 0, 0, 0);
  endtask

  task automatic t_disabled();
    rx_en = 0;
    send(8'h77, 8, 0, 0, 1, 1);
    check("R11 disabled ignores line", fill_cnt, 0);
    rx_en = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_tick();
    tdiv = 2;
    repeat (4) @(negedge clk);
    send(8'hC3, 8, 0, 0, 1, 1);
    check("R12 slow tick data", rx_data, 8'hC3);
    check("R12 slow tick fill", fill_cnt, 1);
    pop();
    tdiv = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_coincide();
    int o0;
    send(8'h4B, 8, 0, 0, 1, 1);
    o0 = ovr_seen;
    fork
      send(8'hB4, 8, 0, 0, 1, 1);
      begin
        repeat (155) @(posedge clk);
        @(negedge clk) rd_pop = 1'b1;
        @(negedge clk) rd_pop = 1'b0;
      end
    join
    check("R7 store+pop fill", fill_cnt, 1);
    check("R7 store+pop head", rx_data, 8'hB4);
    check("R8 no overrun on coincide", ovr_seen, o0);
    pop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    rx_en = 1;
    repeat (4) @(negedge clk);
    t_basic();
    t_seven();
    t_parity();
    t_nopar();
    t_stop();
    t_glitch();
    t_fifo_irq();
    t_err_irq();
    t_disabled();
    t_tick();
    t_coincide();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule